// File: doc/BRIEF.md
# Snapshot Double-Buffered Digital I/O Port

This block is the data path of a digital I/O module that moves a group of discrete points over an 8-bit host bus. In its input form, a scan-start strobe captures every input pin in the same clock edge into a holding register. The host then reads that frozen image one byte at a time. Every byte it reads therefore belongs to the same instant, even when the pins change between the byte reads.

In its output form, the host writes each byte into a staging register. For a 16-point port it writes the low byte first and then the high byte. The next scan-start strobe copies the whole staged image to the output pins in one edge, so no output ever shows a half-updated word. The sequence repeats every scan cycle. Bus accesses count only when the module's chip select is low together with the read or write strobe. The point count is a parameter and must be a multiple of 8. A 16-point port needs two byte transfers per direction and a 32-point port needs four.

Top module: `snap_io_port`

## Requirements
- R1: After reset (synchronous, active-low `rst_n`), `pin_out` is all zeros and both input bytes read back as zero until the first scan-start strobe.
- R2: A clock edge with `scan_stb` high captures all of `pin_in` into the input image at once. Later changes on `pin_in` do not affect reads until the next strobe.
- R3: A qualified read returns the input image byte picked by `byte_sel`, combinationally in the same cycle. `byte_sel`=0 gives points 7..0 and `byte_sel`=1 gives points 15..8.
- R4: `rdata` is 0 whenever `cs_n` or `rd_n` is high.
- R5: A clock edge with `cs_n` and `wr_n` both low stores `wdata` into staging byte `byte_sel` (0 = points 7..0, 1 = points 15..8). `pin_out` does not change because of the write.
- R6: A clock edge with `scan_stb` high copies all staged bytes to `pin_out` together. Between strobes, `pin_out` holds its value.
- R7: A write cycle with `cs_n` high or `wr_n` high leaves the staging registers unchanged. This shows on `pin_out` after the next strobe.
- R8: When a write and `scan_stb` occur in the same edge, `pin_out` takes the staged image from before that write. The newly written byte reaches `pin_out` at the following strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_stb | input | 1 | Scan-start strobe: snapshot inputs, update outputs |
| cs_n | input | 1 | Module chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| byte_sel | input | SEL_W (1) | Byte index within the port |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data |
| pin_in | input | N_POINTS (16) | Input points |
| pin_out | output | N_POINTS (16) | Output points |

## Verification
Directed sequences cover four cases. Changing pins after a snapshot separates a true frozen image from a live read. Write-then-strobe ordering separates staged data from visible outputs. Unqualified strobes separate a gated bus from an ungated one. A write that coincides with a strobe separates old-image transfer from write-through. Random cycles then mix strobes, qualified and unqualified reads and writes, and byte selects with random pin values. These cycles expose swapped bytes, dropped bytes and outputs that change at the wrong edge.

// File: rtl/snap_io_pkg.sv
// Package: shared constants and helpers for the snapshot I/O port.
// Assumes the point count is a positive multiple of the byte width.
package snap_io_pkg;
    localparam int BYTE_W = 8;

    // Width of the byte index for a given number of bytes (at least 1).
    function automatic int sel_width(input int n_bytes);
        return (n_bytes > 1) ? $clog2(n_bytes) : 1;
    endfunction
endpackage

// File: rtl/snap_in_bank.sv
// Module: input snapshot register and byte read multiplexer.
// Captures all points on the scan strobe. Returns the selected byte while
// a qualified read is active and zero otherwise.
module snap_in_bank
    import snap_io_pkg::*;
#(
    parameter int N_POINTS = 16,
    localparam int N_BYTES = N_POINTS / BYTE_W,
    localparam int SEL_W   = sel_width(N_BYTES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                snap_en,
    input  logic                rd_en,
    input  logic [SEL_W-1:0]    sel,
    input  logic [N_POINTS-1:0] pins,
    output logic [BYTE_W-1:0]   rdata
);
    logic [N_POINTS-1:0] snap_q;

    // Purpose: freeze every input point in the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            snap_q <= '0;
        else if (snap_en)
            snap_q <= pins;
    end

    // Purpose: drive the selected image byte onto the read bus when qualified.
    always_comb begin
        rdata = '0;
        if (rd_en)
            rdata = snap_q[sel*BYTE_W +: BYTE_W];
    end

    // R2: the image follows the pins only through a strobe.
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        snap_en |=> snap_q == $past(pins));
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_en |=> $stable(snap_q));
endmodule

// File: rtl/stage_out_bank.sv
// Module: per-byte staging registers and the output latch.
// Staging bytes load on qualified writes. The output latch copies the
// whole staged image on the scan strobe and holds it between strobes.
module stage_out_bank
    import snap_io_pkg::*;
#(
    parameter int N_POINTS = 16,
    localparam int N_BYTES = N_POINTS / BYTE_W,
    localparam int SEL_W   = sel_width(N_BYTES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_en,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    sel,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [N_POINTS-1:0] pins
);
    logic [N_POINTS-1:0] stage_q;
    logic [N_POINTS-1:0] out_q;

    for (genvar g = 0; g < N_BYTES; g++) begin : g_stage
        // Purpose: capture a host byte into this staging slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stage_q[g*BYTE_W +: BYTE_W] <= '0;
            else if (wr_en && (sel == SEL_W'(g)))
                stage_q[g*BYTE_W +: BYTE_W] <= wdata;
        end
    end

    // Purpose: move the full staged image to the pins in one edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '0;
        else if (load_en)
            out_q <= stage_q;
    end

    assign pins = out_q;

    // R5 and R7: staging changes only on a qualified write.
    a_r7_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(stage_q));
    // R6 and R8: the strobe transfers the image staged before that edge.
    a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> out_q == $past(stage_q));
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(out_q));
endmodule

// File: rtl/snap_io_port.sv
// Module: top of the snapshot double-buffered digital I/O port.
// Qualifies bus strobes with chip select and ties both directions to the
// shared scan-start strobe. Assumes N_POINTS is a multiple of 8.
module snap_io_port
    import snap_io_pkg::*;
#(
    parameter int N_POINTS = 16,
    localparam int N_BYTES = N_POINTS / BYTE_W,
    localparam int SEL_W   = sel_width(N_BYTES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scan_stb,
    input  logic                cs_n,
    input  logic                rd_n,
    input  logic                wr_n,
    input  logic [SEL_W-1:0]    byte_sel,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [BYTE_W-1:0]   rdata,
    input  logic [N_POINTS-1:0] pin_in,
    output logic [N_POINTS-1:0] pin_out
);
    logic rd_en;
    logic wr_en;

    // Purpose: accept a bus access only while the module is selected.
    assign rd_en = !cs_n && !rd_n;
    assign wr_en = !cs_n && !wr_n;

    snap_in_bank #(.N_POINTS(N_POINTS)) u_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .snap_en (scan_stb),
        .rd_en   (rd_en),
        .sel     (byte_sel),
        .pins    (pin_in),
        .rdata   (rdata)
    );

    stage_out_bank #(.N_POINTS(N_POINTS)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (scan_stb),
        .wr_en   (wr_en),
        .sel     (byte_sel),
        .wdata   (wdata),
        .pins    (pin_out)
    );

    // R4: an unqualified cycle never drives read data.
    a_r4_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> (rdata == '0));
endmodule

// File: tb/snap_io_port_tb_top.sv
// Bench: directed corner cases plus seeded random cycles, checked against
// a reference model held in bench variables.
module snap_io_port_tb_top;
    localparam int NP = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scan_stb = 1'b0;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [0:0]  byte_sel = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [NP-1:0] m_snap = '0;
    logic [NP-1:0] m_stage = '0;
    logic [NP-1:0] m_out = '0;

    always #5 clk = ~clk;

    snap_io_port #(.N_POINTS(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .scan_stb(scan_stb), .cs_n(cs_n),
        .rd_n(rd_n), .wr_n(wr_n), .byte_sel(byte_sel), .wdata(wdata),
        .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out)
    );

    function automatic logic [7:0] pick(input logic [NP-1:0] v, input int s);
        return 8'((v >> (8*s)) & 16'h00FF);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at the falling edge, check mid-cycle, update the model.
    task automatic step(input bit scan, input bit c, input bit r, input bit w,
                        input int s, input logic [7:0] d, input logic [NP-1:0] p,
                        input string tag);
        logic [NP-1:0] old_stage;
        @(negedge clk);
        scan_stb = scan; cs_n = c; rd_n = r; wr_n = w;
        byte_sel = 1'(s); wdata = d; pin_in = p;
        #1;
        chk({tag, " rdata"}, 32'(rdata), (!c && !r) ? 32'(pick(m_snap, s)) : 32'd0);
        chk({tag, " pin_out"}, 32'(pin_out), 32'(m_out));
        @(posedge clk);
        old_stage = m_stage;
        if (!c && !w) m_stage[8*s +: 8] = d;
        if (scan) begin
            m_out = old_stage;
            m_snap = p;
        end
    endtask

    initial begin
        #2000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset state on outputs and on both image bytes.
        step(0, 0, 0, 1, 0, 8'h00, 16'hFFFF, "R1");
        step(0, 0, 0, 1, 1, 8'h00, 16'hFFFF, "R1");
        // R2: snapshot, then move the pins; reads return the frozen image.
        step(1, 1, 1, 1, 0, 8'h00, 16'hA55A, "R2");
        step(0, 0, 0, 1, 0, 8'h00, 16'h0FF0, "R2");
        step(0, 0, 0, 1, 1, 8'h00, 16'h1234, "R3");
        // R5: stage low then high byte; pins stay put until the strobe.
        step(0, 0, 1, 0, 0, 8'h3C, 16'h0, "R5");
        step(0, 0, 1, 0, 1, 8'hC3, 16'h0, "R5");
        step(1, 1, 1, 1, 0, 8'h00, 16'h0, "R5");
        step(0, 1, 1, 1, 0, 8'h00, 16'h0, "R6");
        // R7: unqualified writes, then a strobe; pins must keep C33C.
        step(0, 1, 1, 0, 0, 8'hEE, 16'h0, "R7");
        step(0, 0, 1, 1, 1, 8'hDD, 16'h0, "R7");
        step(1, 1, 1, 1, 0, 8'h00, 16'h0, "R7");
        step(0, 1, 1, 1, 0, 8'h00, 16'h0, "R7");
        // R4: read strobe without select returns zero.
        step(0, 1, 0, 1, 1, 8'h00, 16'h0, "R4");
        // R8: write coinciding with the strobe lands one scan later.
        step(1, 0, 1, 0, 1, 8'h77, 16'h0, "R8");
        step(0, 1, 1, 1, 0, 8'h00, 16'h0, "R8");
        step(1, 1, 1, 1, 0, 8'h00, 16'h0, "R8");
        step(0, 1, 1, 1, 0, 8'h00, 16'h0, "R8");
        // Random mix of strobes and bus cycles, checked under R3 and R6.
        for (int i = 0; i < 400; i++) begin
            step(($urandom % 4) == 0, ($urandom % 3) == 0, $urandom % 2,
                 $urandom % 2, int'($urandom % 2), 8'($urandom),
                 NP'($urandom), "R3/R6 random");
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule